// File: doc/BRIEF.md
# Seven-Tap Weighted Averaging Filter

This block smooths a stream of signed conversion results. Each time a new sample is presented with its valid strobe, the block forms a weighted sum of that sample and the six samples that came before it. The newest sample counts twice and each older sample counts once, so the eight weight units divide out exactly by eight. The sum is divided with a right shift by three. The block produces one filtered result for every accepted sample, and it never drops or merges samples.

The delay line advances only on a valid input, so idle cycles between samples have no effect on the result. The block takes an asynchronous active-low reset that the surrounding logic releases synchronously. Reset clears the sample history, so the first six results after reset are computed as if the earlier samples were zero. The result and its valid flag are registered, and each result appears on the clock after the sample that produced it.

Top module: `wavg7_filter`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and it is low in every other cycle.
- R3: Both ports are two's complement. When `x0` is the sample accepted on a clock and `x1`..`x6` are the six samples accepted before it, the result on the next clock is floor((2*x0 + x1 + x2 + x3 + x4 + x5 + x6) / 8).
- R4: A single nonzero sample affects exactly seven consecutive results. An impulse of 64 in a zero stream gives 16, then 8 six times, then 0.
- R5: After reset the history reads as zero, so the first results use zero in place of the samples that are missing.
- R6: The division by eight truncates toward negative infinity. A lone sample of -1 after reset gives -1, and a lone sample of 1 gives 0.
- R7: The internal sum never overflows. Seven consecutive samples at the most positive value give that value, and seven at the most negative value give that value.
- R8: While `in_valid` is low, `out_data` holds its last value and the history does not advance, so idle gaps between samples do not change any result.
- R9: A reset asserted in the middle of a stream clears the history, so results after the reset depend only on samples accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | The input sample is valid this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | The filtered result is valid this cycle |
| out_data | output | DATA_W | Signed filtered result |

## Verification
The bench builds the filter with DATA_W set to 8. With that width, the full-scale extremes of +127 and -128 can be reached in a few samples, so the overflow limit of the sum is tested directly. The same width keeps impulse responses and the rounding of small negative values easy to read. A scoreboard model runs alongside the filter and checks every result, both with back-to-back samples and with irregular idle gaps between them.

// File: rtl/wavg7_pkg.sv
package wavg7_pkg;
  // Number of delayed samples kept beside the current one.
  localparam int HIST_TAPS  = 6;
  // Total weight units: current sample twice plus one per delayed sample.
  localparam int WEIGHT_SUM = 2 + HIST_TAPS;
  // Normalisation shift; WEIGHT_SUM is a power of two.
  localparam int NORM_SHIFT = $clog2(WEIGHT_SUM);
  // Extra sum bits needed so the weighted sum cannot overflow.
  localparam int GROWTH_BITS = NORM_SHIFT;
endpackage

// File: rtl/wavg7_history.sv
module wavg7_history
  import wavg7_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = HIST_TAPS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] taps_o [DEPTH]
);

  logic signed [DATA_W-1:0] stage_q [DEPTH];
  logic signed [DATA_W-1:0] stage_d [DEPTH];

  // Next-state: stage 0 takes the new sample, each later stage takes its neighbour.
  always_comb begin
    stage_d[0] = shift_en ? din : stage_q[0];
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_chain
    always_comb begin
      stage_d[g] = shift_en ? stage_q[g-1] : stage_q[g];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
    assign taps_o[g] = stage_q[g];

    // Idle cycles leave every stage untouched (R8).
    p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(stage_q[g]));
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_order_chk
    // Each accepted sample moves every stored sample one position older (R4).
    p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> stage_q[g] == $past(stage_q[g-1]));
  end

endmodule

// File: rtl/wavg7_sum.sv
module wavg7_sum
  import wavg7_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = HIST_TAPS,
  localparam int ACC_W = DATA_W + GROWTH_BITS
) (
  input  logic signed [DATA_W-1:0] cur_i,
  input  logic signed [DATA_W-1:0] taps_i [DEPTH],
  output logic signed [ACC_W-1:0]  acc_o
);

  logic signed [ACC_W-1:0] cur_ext;
  logic signed [ACC_W-1:0] acc_c;

  always_comb begin
    cur_ext = ACC_W'(cur_i);
    acc_c   = cur_ext + cur_ext;
    for (int k = 0; k < DEPTH; k++) begin
      acc_c = acc_c + ACC_W'(taps_i[k]);
    end
  end

  assign acc_o = acc_c;

endmodule

// File: rtl/wavg7_outreg.sv
module wavg7_outreg
  import wavg7_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int ACC_W = DATA_W + GROWTH_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] data_o
);

  logic                     valid_q, valid_d;
  logic signed [DATA_W-1:0] data_q, data_d;

  // Dropping the low NORM_SHIFT bits is an arithmetic shift that rounds down.
  always_comb begin
    valid_d = load_en;
    data_d  = load_en ? acc_i[ACC_W-1:NORM_SHIFT] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/wavg7_filter.sv
module wavg7_filter
  import wavg7_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);

  localparam int ACC_W = DATA_W + GROWTH_BITS;

  logic signed [DATA_W-1:0] hist [HIST_TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic                     hist_zero;

  wavg7_history #(.DATA_W(DATA_W), .DEPTH(HIST_TAPS)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_valid),
    .din      (in_data),
    .taps_o   (hist)
  );

  wavg7_sum #(.DATA_W(DATA_W), .DEPTH(HIST_TAPS)) u_sum (
    .cur_i  (in_data),
    .taps_i (hist),
    .acc_o  (acc)
  );

  wavg7_outreg #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (in_valid),
    .acc_i   (acc),
    .valid_o (out_valid),
    .data_o  (out_data)
  );

  always_comb begin
    hist_zero = 1'b1;
    for (int k = 0; k < HIST_TAPS; k++) begin
      if (hist[k] != '0) hist_zero = 1'b0;
    end
  end

  // Exactly one result per accepted sample, one clock later (R2).
  p_valid_after_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // Result is held across idle cycles (R8).
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // An all-zero window gives a zero result (R5).
  p_zero_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0 && hist_zero) |=> out_data == '0);

  // Reset state on the outputs (R1).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_out_r1: assert (!out_valid && out_data == '0);
    end
  end

endmodule

// File: tb/tb_wavg7_filter.sv
module tb_wavg7_filter;
  localparam int DW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  wavg7_filter #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct { int val; string tag; } exp_t;
  exp_t q[$];
  int   mh [6];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   last_out = 0;
  bit   done     = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 6; k++) mh[k] = 0;
  endtask

  // Driver: compute the expected result, queue it, present the sample.
  task automatic push(input int x, input string tag);
    int s;
    exp_t e;
    s = 2 * x;
    for (int k = 0; k < 6; k++) s += mh[k];
    for (int k = 5; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = x;
    e.val = s >>> 3;
    e.tag = tag;
    @(negedge clk);
    q.push_back(e);
    in_valid = 1'b1;
    in_data  = DW'(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = DW'(8'h5A + i);  // junk data while idle must be ignored (R8)
    end
  endtask

  task automatic drain();
    idle(1);
    for (int i = 0; i < 20 && q.size() != 0; i++) @(negedge clk);
    check(q.size() == 0, "R2 result missing", q.size(), 0);
  endtask

  // Monitor: pop and compare every result; check holding when idle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", int'(out_data), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(out_data) == e.val, e.tag, int'(out_data), e.val);
        end
        last_out = int'(out_data);
      end else begin
        check(int'(out_data) == last_out, "R8 hold while idle", int'(out_data), last_out);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_clear();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    check(out_data == '0, "R1 reset out_data", int'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R4/R5: impulse response from a zero history.
    push(64, "R4 impulse");
    for (int i = 0; i < 7; i++) push(0, "R4 impulse tail");
    drain();

    // R6: rounding toward negative infinity.
    push(-1, "R6 lone -1");
    for (int i = 0; i < 6; i++) push(0, "R6 flush");
    push(1, "R6 lone +1");
    for (int i = 0; i < 6; i++) push(0, "R6 flush");
    push(-9, "R6 -9 gives -3");
    drain();

    // R7: full-scale extremes.
    for (int i = 0; i < 7; i++) push(127, "R7 max run");
    for (int i = 0; i < 7; i++) push(-128, "R7 min run");
    for (int i = 0; i < 8; i++) push((i % 2) ? 127 : -128, "R7 alternate");
    drain();

    // R8: irregular idle gaps.
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(int'($signed(lfsr[7:0])), "R8 gapped stream");
      idle(int'(lfsr[10:9]) + 1);
    end
    drain();

    // R9/R1: reset in mid-stream.
    for (int i = 0; i < 5; i++) push(100 - 7 * i, "R3 pre-reset");
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    last_out = 0;
    #1;
    check(out_valid == 1'b0, "R1 mid reset out_valid", int'(out_valid), 0);
    check(out_data == '0, "R1 mid reset out_data", int'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    push(40, "R9 first after reset");
    push(-40, "R9 second after reset");
    push(24, "R5 zero-filled history");
    drain();

    // R3: long back-to-back stream.
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(int'($signed(lfsr[7:0])), "R3 back-to-back");
    end
    drain();

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule